// File: doc/BRIEF.md
# Multi-Sequencer Sample FIFO Bank

This block is the digital back end of a converter sample controller. It holds four independent sample sequencers, each owning a 16-entry circular result FIFO. A shared trigger pulse, typically coming from a periodic timer, makes every sequencer that is switched on and set to the timer event code capture one sample. The sample value comes from an internal linear congruential noise generator, so software sees varying data without any analogue front end being modelled.

Software reaches the block through a simple single-cycle register bus with separate write and read strobes. It enables sequencers, picks their trigger event, unmasks their interrupt lines, pops results and inspects a packed per-FIFO status word holding both pointers and the empty and full flags. Overflow (capture into a full FIFO) and underflow (pop from an empty one) are latched per sequencer until software writes ones to clear them. Read data is registered: it appears on `busRData` after the clock edge that samples `busRd`, and any register read returns the value held before that edge.

Global registers: 0x00 enable bits (bits 3:0), 0x04 event-select fields (4 bits per sequencer), 0x08 interrupt mask (bits 3:0), 0x0C raw interrupt bits, 0x10 overflow bits, 0x14 underflow bits. Sequencer n occupies 0x40 + 0x20·n: mux setting at +0x0, control word at +0x4, FIFO pop at +0x8, FIFO status at +0xC. Unmapped reads return zero.

Top module: `sample_fifo_bank`

## Requirements
- R1: After reset every FIFO status word reads 0x100 (only the empty flag), the noise state is zero, and the enable, mask, raw, overflow and underflow registers read zero with all `irq` lines low.
- R2: A `trigPulse` captures into sequencer n only when enable bit n (register 0x00) is set and the event-select field at bits 4n+3:4n of register 0x04 equals 5; otherwise that sequencer's FIFO is unchanged.
- R3: Each capture updates noise = noise·314159 + 1 modulo 2^32 and stores 0x200 plus bits 18:16 of the new noise value; when several sequencers capture on the same pulse, the noise advances once per sequencer in ascending index order.
- R4: The status word at +0xC holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty at bit 8 and full at bit 12; after a store, full is set when the write pointer equals the read pointer, and after a pop, empty is set when the read pointer equals the write pointer.
- R5: A read strobe at +0x8 of sequencer n returns the entry at the read pointer and then advances the read pointer by one (modulo 16).
- R6: A capture into a full FIFO discards the sample and sets overflow bit n (register 0x10); the raw interrupt bit n is still set.
- R7: A pop from an empty FIFO sets underflow bit n (register 0x14) and leaves the read pointer unchanged.
- R8: Every capture into sequencer n sets raw bit n (register 0x0C); writing ones to 0x0C clears those bits, and a capture in the same cycle as a clear wins.
- R9: Interrupt line `irq[n]` is raw bit n AND mask bit n (register 0x08).
- R10: Writing ones to register 0x10 or 0x14 clears the matching overflow or underflow bits; zero bits leave them unchanged.
- R11: A write to +0x0 stores the value ANDed with 0x33333333, a write to +0x4 stores the full value, and writes to the pop (+0x8) or status (+0xC) offsets have no effect.
- R12: A pop and a capture on the same sequencer in the same cycle act as pop first, then capture, so a full FIFO accepts the new sample without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops at FIFO offsets) |
| busAddr | input | 8 | Register byte address |
| busWData | input | 32 | Write data |
| trigPulse | input | 1 | Shared capture trigger, one cycle per event |
| busRData | output | 32 | Registered read data, valid after the read edge |
| irq | output | 4 | Per-sequencer interrupt lines |

## Verification
A behavioural model using queues drives the expected values, and the interrupt lines are compared on every clock. Triggers are tried with no sequencer enabled, with an enabled sequencer using a wrong event code, and with two sequencers firing together, which separates qualification faults from noise ordering faults. A long run of triggers into one FIFO walks it to full and one past it to expose overflow and wrap-around of the write pointer, and draining it one pop too many exposes underflow and the frozen read pointer. A pop coinciding with a capture on a full FIFO separates pop-first ordering from push-first ordering.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  // Bank geometry
  parameter int SEQ_N   = 4;
  parameter int DEPTH   = 16;
  parameter int PTR_W   = $clog2(DEPTH);
  parameter int SMP_W   = 10;
  parameter int EVSEL_W = 4;
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 32;
  parameter int STRIDE_LG = 5;

  // Status word layout
  parameter int ST_RD_LSB = 0;
  parameter int ST_WR_LSB = 4;
  parameter int ST_EMPTY  = 8;
  parameter int ST_FULL   = 12;

  // Noise generator
  parameter logic [31:0] NOISE_MUL = 32'd314159;
  parameter logic [31:0] NOISE_INC = 32'd1;
  parameter int NOISE_LSB = 16;
  parameter int NOISE_BITS = 3;
  parameter logic [SMP_W-1:0] SAMPLE_BASE = SMP_W'(10'h200);
  parameter logic [EVSEL_W-1:0] TRIG_CODE = EVSEL_W'(5);

  // Register map
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h00;
  parameter logic [ADDR_W-1:0] EVS_ADDR  = 8'h04;
  parameter logic [ADDR_W-1:0] MSK_ADDR  = 8'h08;
  parameter logic [ADDR_W-1:0] RAW_ADDR  = 8'h0C;
  parameter logic [ADDR_W-1:0] OVF_ADDR  = 8'h10;
  parameter logic [ADDR_W-1:0] UNF_ADDR  = 8'h14;
  parameter logic [ADDR_W-1:0] SEQ_BASE  = 8'h40;
  parameter logic [STRIDE_LG-1:0] MUX_OFF  = 5'h00;
  parameter logic [STRIDE_LG-1:0] CTL_OFF  = 5'h04;
  parameter logic [STRIDE_LG-1:0] POP_OFF  = 5'h08;
  parameter logic [STRIDE_LG-1:0] STAT_OFF = 5'h0C;
  parameter logic [DATA_W-1:0] MUX_KEEP = 32'h3333_3333;

  // Control to datapath strobes
  typedef struct packed {
    logic [SEQ_N-1:0]            push;
    logic [SEQ_N-1:0]            pop;
    logic [SEQ_N-1:0][SMP_W-1:0] sample;
  } laneCmd_t;

  // Datapath to control events
  typedef struct packed {
    logic [SEQ_N-1:0] ovf;
    logic [SEQ_N-1:0] unf;
  } laneEvt_t;
endpackage

// File: rtl/sfb_datapath.sv
module sfb_datapath
  import sfb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  laneCmd_t                      cmd,
  output laneEvt_t                      evt,
  output logic [SEQ_N-1:0][DATA_W-1:0]  stat,
  output logic [SEQ_N-1:0][SMP_W-1:0]   popData
);
  logic [SEQ_N-1:0] ovfV;
  logic [SEQ_N-1:0] unfV;

  for (genvar g = 0; g < SEQ_N; g++) begin : g_lane
    logic [SMP_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head, tail, headN, tailN;
    logic empty, full, emptyN, fullN;
    logic wrEn, ovfEvt, unfEvt;

    // Pop is evaluated first, the capture sees the post-pop state
    always_comb begin
      headN  = head;
      tailN  = tail;
      emptyN = empty;
      fullN  = full;
      wrEn   = 1'b0;
      ovfEvt = 1'b0;
      unfEvt = 1'b0;
      if (cmd.pop[g]) begin
        if (empty) begin
          unfEvt = 1'b1;
        end else begin
          tailN  = tail + PTR_W'(1);
          fullN  = 1'b0;
          emptyN = (tailN == head);
        end
      end
      if (cmd.push[g]) begin
        if (fullN) begin
          ovfEvt = 1'b1;
        end else begin
          wrEn   = 1'b1;
          headN  = head + PTR_W'(1);
          emptyN = 1'b0;
          fullN  = (headN == tailN);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        head  <= '0;
        tail  <= '0;
        empty <= 1'b1;
        full  <= 1'b0;
      end else begin
        head  <= headN;
        tail  <= tailN;
        empty <= emptyN;
        full  <= fullN;
      end
    end

    always_ff @(posedge clk) begin
      if (wrEn) mem[head] <= cmd.sample[g];
    end

    assign popData[g] = mem[tail];
    assign ovfV[g]    = ovfEvt;
    assign unfV[g]    = unfEvt;

    always_comb begin
      stat[g] = '0;
      stat[g][ST_RD_LSB +: PTR_W] = tail;
      stat[g][ST_WR_LSB +: PTR_W] = head;
      stat[g][ST_EMPTY]           = empty;
      stat[g][ST_FULL]            = full;
    end
  end

  assign evt.ovf = ovfV;
  assign evt.unf = unfV;
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
  import sfb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWData,
  input  logic                          trigPulse,
  input  laneEvt_t                      evt,
  input  logic [SEQ_N-1:0][DATA_W-1:0]  stat,
  input  logic [SEQ_N-1:0][SMP_W-1:0]   popData,
  output laneCmd_t                      cmd,
  output logic [DATA_W-1:0]             busRData,
  output logic [SEQ_N-1:0]              irq
);
  localparam int SEL_W  = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
  localparam int EVS_W  = SEQ_N * EVSEL_W;
  localparam int SPAN   = SEQ_N << STRIDE_LG;

  logic [SEQ_N-1:0]           enaQ, mskQ, rawQ, ovfQ, unfQ;
  logic [EVS_W-1:0]           evsQ;
  logic [31:0]                noiseQ, noiseD;
  logic [SEQ_N-1:0][DATA_W-1:0] muxQ, ctlQ;
  logic [DATA_W-1:0]          rdDataQ, rdNext;

  logic [ADDR_W-1:0]    offs;
  logic                 inSeq;
  logic [SEL_W-1:0]     seqIdx;
  logic [STRIDE_LG-1:0] sub;
  logic [SEQ_N-1:0]     rawClr, ovfClr, unfClr;

  // Address decode
  always_comb begin
    offs   = busAddr - SEQ_BASE;
    inSeq  = (busAddr >= SEQ_BASE) && (32'(offs) < SPAN);
    seqIdx = offs[STRIDE_LG +: SEL_W];
    sub    = offs[STRIDE_LG-1:0];
  end

  // Trigger qualification and chained noise update, lowest index first
  always_comb begin
    logic [31:0] nz;
    nz  = noiseQ;
    cmd = '0;
    for (int n = 0; n < SEQ_N; n++) begin
      if (trigPulse && enaQ[n] &&
          evsQ[n*EVSEL_W +: EVSEL_W] == TRIG_CODE) begin
        nz = nz * NOISE_MUL + NOISE_INC;
        cmd.push[n]   = 1'b1;
        cmd.sample[n] = SAMPLE_BASE + SMP_W'(nz[NOISE_LSB +: NOISE_BITS]);
      end
    end
    noiseD = nz;
    if (busRd && inSeq && sub == POP_OFF) cmd.pop[seqIdx] = 1'b1;
  end

  // Write-one-to-clear masks
  always_comb begin
    rawClr = '0;
    ovfClr = '0;
    unfClr = '0;
    if (busWr) begin
      if (busAddr == RAW_ADDR) rawClr = busWData[SEQ_N-1:0];
      if (busAddr == OVF_ADDR) ovfClr = busWData[SEQ_N-1:0];
      if (busAddr == UNF_ADDR) unfClr = busWData[SEQ_N-1:0];
    end
  end

  // Read multiplexer
  always_comb begin
    rdNext = '0;
    if (inSeq) begin
      case (sub)
        MUX_OFF:  rdNext = muxQ[seqIdx];
        CTL_OFF:  rdNext = ctlQ[seqIdx];
        POP_OFF:  rdNext = DATA_W'(popData[seqIdx]);
        STAT_OFF: rdNext = stat[seqIdx];
        default:  rdNext = '0;
      endcase
    end else begin
      case (busAddr)
        ENA_ADDR: rdNext = DATA_W'(enaQ);
        EVS_ADDR: rdNext = DATA_W'(evsQ);
        MSK_ADDR: rdNext = DATA_W'(mskQ);
        RAW_ADDR: rdNext = DATA_W'(rawQ);
        OVF_ADDR: rdNext = DATA_W'(ovfQ);
        UNF_ADDR: rdNext = DATA_W'(unfQ);
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enaQ    <= '0;
      mskQ    <= '0;
      rawQ    <= '0;
      ovfQ    <= '0;
      unfQ    <= '0;
      evsQ    <= '0;
      noiseQ  <= '0;
      muxQ    <= '0;
      ctlQ    <= '0;
      rdDataQ <= '0;
    end else begin
      noiseQ <= noiseD;
      rawQ   <= (rawQ & ~rawClr) | cmd.push;
      ovfQ   <= (ovfQ & ~ovfClr) | evt.ovf;
      unfQ   <= (unfQ & ~unfClr) | evt.unf;
      if (busWr) begin
        if (busAddr == ENA_ADDR) enaQ <= busWData[SEQ_N-1:0];
        if (busAddr == EVS_ADDR) evsQ <= busWData[EVS_W-1:0];
        if (busAddr == MSK_ADDR) mskQ <= busWData[SEQ_N-1:0];
        if (inSeq && sub == MUX_OFF) muxQ[seqIdx] <= busWData & MUX_KEEP;
        if (inSeq && sub == CTL_OFF) ctlQ[seqIdx] <= busWData;
      end
      if (busRd) rdDataQ <= rdNext;
    end
  end

  assign busRData = rdDataQ;
  assign irq      = rawQ & mskQ;
endmodule

// File: rtl/sample_fifo_bank.sv
module sample_fifo_bank
  import sfb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWData,
  input  logic              trigPulse,
  output logic [31:0]       busRData,
  output logic [3:0]        irq
);
  laneCmd_t                     cmd;
  laneEvt_t                     evt;
  logic [SEQ_N-1:0][DATA_W-1:0] stat;
  logic [SEQ_N-1:0][SMP_W-1:0]  popData;

  sfb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWData(busWData),
    .trigPulse(trigPulse),
    .evt(evt), .stat(stat), .popData(popData),
    .cmd(cmd), .busRData(busRData), .irq(irq)
  );

  sfb_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .evt(evt), .stat(stat), .popData(popData)
  );
endmodule

// File: rtl/sfb_chk.sv
module sfb_chk
  import sfb_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          busWr,
  input logic                          busRd,
  input logic                          trigPulse,
  input logic [SEQ_N-1:0]              irq,
  input logic [SEQ_N-1:0][DATA_W-1:0]  stat
);
  for (genvar g = 0; g < SEQ_N; g++) begin : g_chk
    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(stat[g][ST_EMPTY] && stat[g][ST_FULL]));
    // R4
    empty_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
      stat[g][ST_EMPTY] |-> stat[g][ST_RD_LSB +: PTR_W] == stat[g][ST_WR_LSB +: PTR_W]);
    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(trigPulse) |-> $stable(stat[g][ST_WR_LSB +: PTR_W]));
    // R5
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(busRd) |-> $stable(stat[g][ST_RD_LSB +: PTR_W]));
    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[g]) |-> $past(trigPulse || busWr));
  end
endmodule

bind sample_fifo_bank sfb_chk u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
  .trigPulse(trigPulse), .irq(irq), .stat(stat)
);

// File: tb/tb_sample_fifo_bank.sv
module tb_sample_fifo_bank;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWr, busRd, trigPulse;
  logic [7:0]  busAddr;
  logic [31:0] busWData;
  logic [31:0] busRData;
  logic [3:0]  irq;

  always #5 clk = ~clk;

  sample_fifo_bank dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWData(busWData), .trigPulse(trigPulse),
    .busRData(busRData), .irq(irq)
  );

  int compared = 0;
  int mismatched = 0;
  bit running = 0;

  // Reference model
  int        q[4][$];
  int        headM[4], tailM[4];
  bit [3:0]  enaM, mskM, rawM, ovfM, unfM;
  bit [15:0] evsM;
  bit [31:0] noiseM;
  bit [31:0] muxM[4], ctlM[4];

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] statM(int n);
    bit [31:0] s;
    s = 32'(tailM[n]) | (32'(headM[n]) << 4);
    if (q[n].size() == 0) s[8] = 1'b1;
    if (q[n].size() == 16) s[12] = 1'b1;
    return s;
  endfunction

  function automatic bit isSeq(bit [7:0] a);
    return a >= 8'h40 && a < 8'hC0;
  endfunction

  function automatic bit [31:0] readM(bit [7:0] a);
    if (isSeq(a)) begin
      int n = int'(a - 8'h40) >> 5;
      case (a[4:0])
        5'h00: return muxM[n];
        5'h04: return ctlM[n];
        5'h0C: return statM(n);
        default: return 0;
      endcase
    end
    case (a)
      8'h00: return 32'(enaM);
      8'h04: return 32'(evsM);
      8'h08: return 32'(mskM);
      8'h0C: return 32'(rawM);
      8'h10: return 32'(ovfM);
      8'h14: return 32'(unfM);
      default: return 0;
    endcase
  endfunction

  task automatic trigM();
    for (int n = 0; n < 4; n++) begin
      if (enaM[n] && ((evsM >> (4*n)) & 16'hF) == 5) begin
        noiseM = noiseM * 32'd314159 + 32'd1;
        rawM[n] = 1'b1;
        if (q[n].size() == 16) ovfM[n] = 1'b1;
        else begin
          q[n].push_back(32'h200 + ((noiseM >> 16) & 7));
          headM[n] = (headM[n] + 1) % 16;
        end
      end
    end
  endtask

  task automatic writeM(bit [7:0] a, bit [31:0] d);
    if (isSeq(a)) begin
      int n = int'(a - 8'h40) >> 5;
      if (a[4:0] == 5'h00) muxM[n] = d & 32'h3333_3333;
      if (a[4:0] == 5'h04) ctlM[n] = d;
      return;
    end
    case (a)
      8'h00: enaM = d[3:0];
      8'h04: evsM = d[15:0];
      8'h08: mskM = d[3:0];
      8'h0C: rawM &= ~d[3:0];
      8'h10: ovfM &= ~d[3:0];
      8'h14: unfM &= ~d[3:0];
      default: ;
    endcase
  endtask

  // One bus cycle; write effects are modelled before captures (clear then set)
  task automatic op(bit wr, bit rd, bit [7:0] a, bit [31:0] d, bit trig, string tag);
    bit [31:0] exp;
    bit chk;
    bit isPop;
    int pn;
    chk   = rd;
    exp   = 0;
    isPop = rd && isSeq(a) && a[4:0] == 5'h08;
    pn    = isSeq(a) ? (int'(a - 8'h40) >> 5) : 0;
    if (rd) begin
      exp = readM(a);
      if (isPop) begin
        if (q[pn].size() == 0) chk = 0;
        else exp = 32'(q[pn][0]);
      end
    end
    busWr = wr; busRd = rd; busAddr = a; busWData = d; trigPulse = trig;
    @(posedge clk);
    #1;
    busWr = 0; busRd = 0; busAddr = 0; busWData = 0; trigPulse = 0;
    if (wr) writeM(a, d);
    if (isPop) begin
      if (q[pn].size() == 0) unfM[pn] = 1'b1;
      else begin
        void'(q[pn].pop_front());
        tailM[pn] = (tailM[pn] + 1) % 16;
      end
    end
    if (trig) trigM();
    if (chk) check(tag, busRData, exp);
  endtask

  task automatic wrR(bit [7:0] a, bit [31:0] d, string tag); op(1, 0, a, d, 0, tag); endtask
  task automatic rdR(bit [7:0] a, string tag);               op(0, 1, a, 0, 0, tag); endtask
  task automatic fire(string tag);                           op(0, 0, 0, 0, 1, tag); endtask

  // Interrupt lines compared every clock
  always @(negedge clk) begin
    if (running) check("R9 irq lines", 32'(irq), 32'(rawM & mskM));
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rstN = 0; busWr = 0; busRd = 0; busAddr = 0; busWData = 0; trigPulse = 0;
    for (int n = 0; n < 4; n++) begin
      headM[n] = 0; tailM[n] = 0; muxM[n] = 0; ctlM[n] = 0;
    end
    enaM = 0; mskM = 0; rawM = 0; ovfM = 0; unfM = 0; evsM = 0; noiseM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    running = 1;

    // R1 reset state
    for (int n = 0; n < 4; n++) rdR(8'h4C + 8'(n * 32), "R1 status after reset");
    rdR(8'h00, "R1 enable after reset");
    rdR(8'h0C, "R1 raw after reset");
    rdR(8'h10, "R1 overflow after reset");
    rdR(8'h14, "R1 underflow after reset");

    // R2 nothing enabled
    fire("R2 idle trigger");
    rdR(8'h4C, "R2 no capture when disabled");

    // R2 seq0 code 5, seq1 enabled with wrong code 4
    wrR(8'h00, 32'h3, "R2 enable");
    wrR(8'h04, 32'h0045, "R2 event select");
    fire("R2 qualified trigger");
    rdR(8'h4C, "R2 seq0 captured");
    rdR(8'h6C, "R2 seq1 wrong code ignored");
    rdR(8'h0C, "R8 raw set by capture");

    // R3 two sequencers on one pulse, ascending order
    wrR(8'h00, 32'h5, "R3 enable 0 and 2");
    wrR(8'h04, 32'h0505, "R3 event select");
    fire("R3 dual trigger a");
    fire("R3 dual trigger b");
    rdR(8'h4C, "R4 seq0 partial status");
    rdR(8'h8C, "R4 seq2 partial status");
    for (int i = 0; i < 3; i++) rdR(8'h48, "R3 R5 seq0 pop data");
    for (int i = 0; i < 2; i++) rdR(8'h88, "R3 R5 seq2 pop data");
    rdR(8'h4C, "R4 seq0 drained status");

    // R9 and R8 interrupt masking and clearing
    wrR(8'h08, 32'h1, "R9 mask seq0");
    wrR(8'h0C, 32'h1, "R8 clear raw bit0");
    rdR(8'h0C, "R8 raw after clear");
    wrR(8'h08, 32'hF, "R9 mask all");
    fire("R8 capture after full mask");
    rdR(8'h0C, "R8 raw set again");

    // R6 fill seq3 and overflow
    wrR(8'h00, 32'h8, "R6 enable seq3");
    wrR(8'h04, 32'h5000, "R6 event select seq3");
    wrR(8'h0C, 32'hF, "R8 clear all raw");
    for (int i = 0; i < 17; i++) fire("R6 fill");
    rdR(8'hAC, "R4 seq3 full status");
    rdR(8'h10, "R6 overflow bit");
    rdR(8'h0C, "R6 raw still set");
    wrR(8'h10, 32'h8, "R10 clear overflow");
    rdR(8'h10, "R10 overflow cleared");

    // R12 pop and capture in one cycle on a full FIFO
    op(0, 1, 8'hA8, 0, 1, "R12 pop with capture");
    rdR(8'hAC, "R12 status stays full");
    rdR(8'h10, "R12 no overflow");

    // R7 drain past empty
    for (int i = 0; i < 17; i++) rdR(8'hA8, "R5 R7 seq3 drain");
    rdR(8'hAC, "R7 read pointer held");
    rdR(8'h14, "R7 underflow bit");
    wrR(8'h14, 32'h1, "R10 clear wrong bit");
    rdR(8'h14, "R10 underflow kept");
    wrR(8'h14, 32'h8, "R10 clear underflow");
    rdR(8'h14, "R10 underflow cleared");

    // R11 per-sequencer registers
    wrR(8'h40, 32'hFFFF_FFFF, "R11 mux write");
    rdR(8'h40, "R11 mux masked");
    wrR(8'h64, 32'h0000_0006, "R11 control write");
    rdR(8'h64, "R11 control stored");
    fire("R11 add entry to seq3");
    wrR(8'hAC, 32'hFFFF_FFFF, "R11 status write");
    wrR(8'hA8, 32'hFFFF_FFFF, "R11 pop write");
    rdR(8'hAC, "R11 status unchanged by writes");
    rdR(8'hA8, "R11 entry intact");

    @(negedge clk);
    running = 0;
    summary();
  end
endmodule